// File: doc/BRIEF.md
# Reset Generation Unit

This block drives a bank of active-high reset lines for the rest of the chip from a small register bus. Software sets a reset by writing 1 to that line's bit in one of the control words. Most lines are pulse lines: once set, a line stays asserted for a fixed number of clock cycles and then releases itself. A few lines are held lines: they stay asserted until software writes 0 to their bit. Line 0 is the whole-system reset.

Software can read each line's state in two ways. The control words read back 1 for every active line. The status words read back the same information inverted, so a 0 there marks an active reset. The line count, the hold time and the set of held lines are parameters. By default there are 64 lines in two 32-bit words, the hold time is 8 cycles, and lines 12 and 56 are the held lines.

Top module: `rst_gen_unit`

## Requirements
- R1: When `rst_n` is low, every reset output goes inactive (0) at once and every hold count is cleared. After release, all control reads are 0 and all status reads are all ones.
- R2: Line n belongs to control word n/32 at bit n%32. Control word 0 is at address 0x100 and word 1 is at 0x104. A write to one word leaves the lines of the other word unchanged.
- R3: A write of 1 to a control bit makes that output 1 after the clock edge that samples the write, and not before.
- R4: A pulse line stays at 1 for exactly HOLD_CYCLES (8) cycles after the write edge, then returns to 0. Another write of 1 while it is active restarts the full hold time from the new write edge.
- R5: A write of 0 to a pulse line's bit has no effect. An idle pulse line stays 0, and an active one keeps its original release time.
- R6: Lines 12 and 56 do not clear themselves. Each stays at 1 until a write to its word places 0 in its bit, and it goes to 0 on the edge that samples that write.
- R7: A read of a control word address returns the current state of its 32 outputs, with 1 meaning active.
- R8: A read of status word 0 (0x150) or status word 1 (0x154) returns the bitwise inverse of the matching outputs, with 0 meaning active.
- R9: A write to any address other than the two control words changes no output. A read of any address other than the four word addresses returns 0.
- R10: Output 0 is the system reset. It is a pulse line and follows R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_out | output | 64 | Active-high reset outputs, one per line |

## Verification
A hold counter left in the wrong state shows up on `rst_out` as a pulse that is too short, too long or never ends. The mismatch is visible on the cycle the line should have released, at most HOLD_CYCLES after the last write. A wrong line type or address decode shows on the edge right after the write: a line sets in the wrong word, a held line drops by itself, or a write of 0 clears a pulse line. Because readback is combinational, any wrong state in the output registers also shows in the same cycle on both the control reads and the inverted status reads.

// File: rtl/rgu_pkg.sv
package rgu_pkg;

  // Kind of register selected by the current bus address
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;

  // Decoded access: register kind and word index (up to 16 words)
  typedef struct packed {
    acc_kind_e   kind;
    logic [3:0]  word;
  } acc_dec_t;

endpackage

// File: rtl/rgu_addr_decode.sv
module rgu_addr_decode
  import rgu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned CTRL_BASE = 32'h100,
  parameter int unsigned STAT_BASE = 32'h150
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_dec_t          dec
);

  localparam int unsigned WORD_BYTES = 4;

  always_comb begin
    dec.kind = ACC_NONE;
    dec.word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(CTRL_BASE + WORD_BYTES * w)) begin
        dec.kind = ACC_CTRL;
        dec.word = 4'(w);
      end
      if (addr == ADDR_W'(STAT_BASE + WORD_BYTES * w)) begin
        dec.kind = ACC_STAT;
        dec.word = 4'(w);
      end
    end
  end

  // R9: a decoded word index never points past the implemented words
  always_comb begin
    if (dec.kind != ACC_NONE) begin
      p_word_in_range_r9: assert (32'(dec.word) < NUM_WORDS);
    end
  end

endmodule

// File: rtl/rgu_line.sv
module rgu_line #(
  parameter int unsigned HOLD_CYCLES = 8,
  parameter bit          HELD        = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic active
);

  logic act_q;
  logic act_d;

  generate
    if (HELD) begin : g_held
      // Level-held line: follows the written bit, keeps it otherwise
      always_comb begin
        act_d = act_q;
        if (wr_en) act_d = wr_bit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     act_q <= 1'b0;
        else if (wr_en) act_q <= act_d;
      end

      p_held_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(act_q));
      p_held_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (act_q == $past(wr_bit)));

    end else begin : g_pulse
      localparam int unsigned CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             set_req;
      logic             upd_en;

      assign set_req = wr_en & wr_bit;
      assign upd_en  = set_req | act_q;

      always_comb begin
        act_d = act_q;
        cnt_d = cnt_q;
        if (set_req) begin
          act_d = 1'b1;
          cnt_d = CNT_LOAD;
        end else if (act_q) begin
          if (cnt_q == '0) act_d = 1'b0;
          else             cnt_d = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else if (upd_en) begin
          act_q <= act_d;
          cnt_q <= cnt_d;
        end
      end

      p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> act_q);
      p_zero_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit && !act_q) |=> !act_q);
      p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && cnt_q == '0 && !set_req) |=> !act_q);
      p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && !set_req) |=> !act_q);
    end
  endgenerate

  assign active = act_q;

endmodule

// File: rtl/rgu_readback.sv
module rgu_readback
  import rgu_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned WORD_W    = 32
) (
  input  acc_dec_t                        dec,
  input  logic [NUM_WORDS*WORD_W-1:0]     line_state,
  output logic [WORD_W-1:0]               rdata
);

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (dec.word == 4'(w)) begin
        unique case (dec.kind)
          ACC_CTRL: rdata = line_state[w*WORD_W +: WORD_W];
          ACC_STAT: rdata = ~line_state[w*WORD_W +: WORD_W];
          default:  rdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/rst_gen_unit.sv
module rst_gen_unit
  import rgu_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 64,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned HOLD_CYCLES = 8,
  parameter int unsigned CTRL_BASE   = 32'h100,
  parameter int unsigned STAT_BASE   = 32'h150,
  parameter logic [NUM_LINES-1:0] HELD_MASK = 64'h0100_0000_0000_1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] rst_out
);

  localparam int unsigned NUM_WORDS = NUM_LINES / WORD_W;

  acc_dec_t             dec;
  logic [NUM_WORDS-1:0] word_we;
  logic [NUM_LINES-1:0] line_state;

  rgu_addr_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .CTRL_BASE (CTRL_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_decode (
    .addr (bus_addr),
    .dec  (dec)
  );

  always_comb begin
    word_we = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      word_we[w] = bus_wr && (dec.kind == ACC_CTRL) && (dec.word == 4'(w));
    end
  end

  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      rgu_line #(
        .HOLD_CYCLES (HOLD_CYCLES),
        .HELD        (HELD_MASK[n])
      ) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (word_we[n / WORD_W]),
        .wr_bit (bus_wdata[n % WORD_W]),
        .active (line_state[n])
      );
    end
  endgenerate

  rgu_readback #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W)
  ) u_readback (
    .dec        (dec),
    .line_state (line_state),
    .rdata      (bus_rdata)
  );

  assign rst_out = line_state;

  // R9/R2: at most one control word is written per cycle
  p_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(word_we));
  // R9: a write that selects no control word changes no output
  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && word_we == '0 && rst_out == '0) |=> (rst_out == '0));

endmodule

// File: tb/test_rst_gen_unit.sv
module test_rst_gen_unit;

  localparam int H = 8;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] rst_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rst_gen_unit i_rst_gen_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_out   (rst_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic bit is_held(input int n);
    return (n == 12) || (n == 56);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after reset
    chk(rst_out == '0, "R1 outputs after reset", rst_out, '0);
    rd(12'h150, d); chk(d == 32'hFFFF_FFFF, "R1 status0 after reset", 64'(d), 64'hFFFF_FFFF);
    rd(12'h104, d); chk(d == 32'h0, "R1 ctrl1 after reset", 64'(d), 64'h0);

    // Sweep over every line: R2, R3, R4, R6, R7, R8, R10
    for (int n = 0; n < 64; n++) begin
      logic [11:0] ca, sa, oa;
      logic [31:0] bm;
      ca = (n < 32) ? 12'h100 : 12'h104;
      sa = (n < 32) ? 12'h150 : 12'h154;
      oa = (n < 32) ? 12'h104 : 12'h100;
      bm = 32'b1 << (n % 32);
      e  = 64'b1 << n;
      wr(ca, bm);
      chk(rst_out == e, (n == 0) ? "R10 system line set" : "R3 R2 line set", rst_out, e);
      rd(ca, d); chk(d == bm, "R7 ctrl readback", 64'(d), 64'(bm));
      rd(sa, d); chk(d == ~bm, "R8 status readback", 64'(d), 64'(~bm));
      rd(oa, d); chk(d == 32'h0, "R2 other word idle", 64'(d), 64'h0);
      repeat (H - 1) @(negedge clk);
      chk(rst_out == e, is_held(n) ? "R6 held line stays" : "R4 still in hold", rst_out, e);
      @(negedge clk);
      if (is_held(n)) begin
        chk(rst_out == e, "R6 held past hold time", rst_out, e);
        wr(ca, 32'h0);
        chk(rst_out == '0, "R6 held line cleared by 0", rst_out, '0);
      end else begin
        chk(rst_out == '0, (n == 0) ? "R10 system line released" : "R4 released",
            rst_out, '0);
      end
    end

    // R4: rewrite restarts hold
    wr(12'h100, 32'h20);
    repeat (3) @(negedge clk);
    wr(12'h100, 32'h20);
    repeat (H - 1) @(negedge clk);
    chk(rst_out == 64'h20, "R4 restart extends hold", rst_out, 64'h20);
    @(negedge clk);
    chk(rst_out == '0, "R4 restart release", rst_out, '0);

    // R5: zero write to active pulse line keeps release time
    wr(12'h100, 32'h8);          // edge k
    @(negedge clk);              // after k+1
    wr(12'h100, 32'h0);          // sampled at k+3
    chk(rst_out == 64'h8, "R5 zero write ignored", rst_out, 64'h8);
    repeat (4) @(negedge clk);   // after k+7
    chk(rst_out == 64'h8, "R5 hold unchanged", rst_out, 64'h8);
    @(negedge clk);              // after k+8
    chk(rst_out == '0, "R5 original release time", rst_out, '0);
    wr(12'h104, 32'h0);
    chk(rst_out == '0, "R5 zero write on idle lines", rst_out, '0);

    // R6 mixed: all ones to both words, held lines remain
    wr(12'h100, 32'hFFFF_FFFF);
    chk(rst_out == 64'h0000_0000_FFFF_FFFF, "R3 all of word 0", rst_out, 64'h0000_0000_FFFF_FFFF);
    repeat (H) @(negedge clk);
    chk(rst_out == 64'h1000, "R6 line 12 remains", rst_out, 64'h1000);
    wr(12'h104, 32'hFFFF_FFFF);
    chk(rst_out == 64'hFFFF_FFFF_0000_1000, "R2 word 1 leaves word 0", rst_out, 64'hFFFF_FFFF_0000_1000);
    repeat (H) @(negedge clk);
    e = 64'h0100_0000_0000_1000;
    chk(rst_out == e, "R6 lines 12 and 56 remain", rst_out, e);
    rd(12'h150, d); chk(d == 32'hFFFF_EFFF, "R8 status0 held", 64'(d), 64'hFFFF_EFFF);
    rd(12'h154, d); chk(d == 32'hFEFF_FFFF, "R8 status1 held", 64'(d), 64'hFEFF_FFFF);
    rd(12'h104, d); chk(d == 32'h0100_0000, "R7 ctrl1 held", 64'(d), 64'h0100_0000);

    // R9: stray writes and reads
    wr(12'h108, 32'hFFFF_FFFF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    wr(12'h150, 32'h0000_0000);
    chk(rst_out == e, "R9 stray writes ignored", rst_out, e);
    rd(12'h108, d); chk(d == 32'h0, "R9 unmapped read", 64'(d), 64'h0);
    rd(12'h000, d); chk(d == 32'h0, "R9 unmapped read low", 64'(d), 64'h0);

    // R1: reset while lines active
    wr(12'h100, 32'h0000_00F1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rst_out == '0, "R1 async clear", rst_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_out == '0, "R1 stays clear after reset", rst_out, '0);
    wr(12'h100, 32'h1);
    repeat (H - 1) @(negedge clk);
    chk(rst_out == 64'h1, "R1 R10 fresh count after reset", rst_out, 64'h1);
    @(negedge clk);
    chk(rst_out == '0, "R1 R10 release after reset", rst_out, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule